// File: doc/BRIEF.md
# UART Xon/Xoff Software Flow Controller

This block sits between one UART channel's byte streams and the rest of the channel and carries out in-band software flow control. Four programmable control characters are supplied on input ports: two "resume" characters (`on_a`, `on_b`) and two "pause" characters (`off_a`, `off_b`). A four-bit mode input chooses which of them are used on each side. The upper pair of mode bits sets what the transmitter inserts. The lower pair sets what the receiver looks for.

On the receive side every byte from the deserialiser is compared with the active characters. A recognised pause character raises `tx_halt`, which holds back local transmit data. A recognised resume character lowers it. Recognised control bytes are removed from the receive stream. When all four mode bits are set, recognition requires the first character immediately followed by the second. A first character that is not followed by its partner is handed on as ordinary data.

On the transmit side, pulses on `send_on` and `send_off` queue a resume or pause character, or the two-character pair. The queued control output goes ahead of any waiting data byte and is not blocked by `tx_halt`. All byte ports use valid/ready handshakes.

Top module: `uart_xonxoff_ctrl`

## Requirements
- R1: After reset `tx_halt` is 0, and with no input activity neither `rx_out_valid` nor `tx_out_valid` is asserted.
- R2: With receive bits mode[1:0]=00 every received byte, including control characters, is passed on unchanged, and `tx_halt` is cleared within one clock.
- R3: With mode[1:0]=10 only `on_a`/`off_a` are recognised, and with 01 only `on_b`/`off_b`. A recognised byte is consumed without appearing on `rx_out`. A pause character sets `tx_halt` and a resume character clears it.
- R4: With mode[1:0]=11 and mode[3:2] not 11, a byte equal to either resume character counts as resume, and a byte equal to either pause character counts as pause.
- R5: With mode=1111, resume is recognised only for `on_a` immediately followed by `on_b`, and pause only for `off_a` immediately followed by `off_b`. Both bytes are consumed.
- R6: With mode=1111, if a held first character is followed by any byte other than its partner, the held byte is output first. The new byte is then handled as a fresh byte.
- R7: Any change of the mode input discards a partially matched first character. That character is never output.
- R8: While `tx_halt` is 1, no data byte is accepted from `tx_in` or sent to `tx_out`. Queued control characters are still sent.
- R9: A request with transmit bits mode[3:2]=10 sends `on_a` or `off_a`. With 01 it sends `on_b` or `off_b`.
- R10: With mode[3:2]=11 a request sends the first character and then the second character on consecutive accepted transfers, with no data byte between them.
- R11: A pending control character is output before any waiting data byte. Data resumes once it has been sent.
- R12: With mode[3:2]=00, `send_on` and `send_off` have no effect on `tx_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 4 | [3:2] transmit selection, [1:0] receive selection |
| on_a | input | 8 | First resume character |
| on_b | input | 8 | Second resume character |
| off_a | input | 8 | First pause character |
| off_b | input | 8 | Second pause character |
| rx_in_valid | input | 1 | Received byte available |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Received byte taken |
| rx_out_valid | output | 1 | Filtered receive byte available |
| rx_out_data | output | 8 | Filtered receive byte |
| rx_out_ready | input | 1 | Downstream takes filtered byte |
| tx_in_valid | input | 1 | Data byte to transmit available |
| tx_in_data | input | 8 | Data byte to transmit |
| tx_in_ready | output | 1 | Data byte taken |
| tx_out_valid | output | 1 | Byte to serialiser available |
| tx_out_data | output | 8 | Byte to serialiser |
| tx_out_ready | input | 1 | Serialiser takes byte |
| send_on | input | 1 | Pulse: queue a resume request |
| send_off | input | 1 | Pulse: queue a pause request (wins if both) |
| tx_halt | output | 1 | Local transmit data is held back |

## Verification
A wrong match decision appears immediately at the ports. The receive output either gains a control byte or loses a data byte in the same cycle the byte is offered, and `tx_halt` shows the wrong level one clock later. A stale partial-match flag shows up on the next received byte, either as an extra released first character or as a missed pair. A broken transmit sequencer shows up within two or three cycles of a request: a missing, swapped or split control pair, or a data byte slipping ahead of it. The bench compares whole output byte streams against a model over randomised mixes of control and data bytes in each receive mode, and checks `tx_halt` after every byte.

// File: rtl/uart_xonxoff_ctrl.sv
module uart_xonxoff_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode,
  input  logic [W-1:0] on_a,
  input  logic [W-1:0] on_b,
  input  logic [W-1:0] off_a,
  input  logic [W-1:0] off_b,
  input  logic         rx_in_valid,
  input  logic [W-1:0] rx_in_data,
  output logic         rx_in_ready,
  output logic         rx_out_valid,
  output logic [W-1:0] rx_out_data,
  input  logic         rx_out_ready,
  input  logic         tx_in_valid,
  input  logic [W-1:0] tx_in_data,
  output logic         tx_in_ready,
  output logic         tx_out_valid,
  output logic [W-1:0] tx_out_data,
  input  logic         tx_out_ready,
  input  logic         send_on,
  input  logic         send_off,
  output logic         tx_halt
);

  wire [1:0] rxm  = mode[1:0];
  wire [1:0] txm  = mode[3:2];
  wire       pair = &mode;

  logic [3:0] mode_q;
  logic hold, hold_off;
  logic req_pend, req_off, sec_pend, sec_off;
  logic ctl_on, ctl_off, set_hold;
  logic is_on, is_off;

  wire mode_chg = mode != mode_q;
  wire hold_eff = hold & ~mode_chg;

  wire m_on1  = rx_in_data == on_a;
  wire m_on2  = rx_in_data == on_b;
  wire m_off1 = rx_in_data == off_a;
  wire m_off2 = rx_in_data == off_b;

  always_comb begin
    case (rxm)
      2'b10:   begin is_on = m_on1;         is_off = m_off1;          end
      2'b01:   begin is_on = m_on2;         is_off = m_off2;          end
      2'b11:   begin is_on = m_on1 | m_on2; is_off = m_off1 | m_off2; end
      default: begin is_on = 1'b0;          is_off = 1'b0;            end
    endcase
  end

  always_comb begin
    rx_out_valid = 1'b0;
    rx_out_data  = rx_in_data;
    rx_in_ready  = rx_out_ready;
    ctl_on       = 1'b0;
    ctl_off      = 1'b0;
    set_hold     = 1'b0;
    if (pair && hold_eff) begin
      if (hold_off ? m_off2 : m_on2) begin
        rx_in_ready = 1'b1;
        ctl_on      = ~hold_off;
        ctl_off     = hold_off;
      end else begin
        rx_out_valid = rx_in_valid;
        rx_out_data  = hold_off ? off_a : on_a;
        rx_in_ready  = 1'b0;
      end
    end else if (pair && (m_on1 || m_off1)) begin
      rx_in_ready = 1'b1;
      set_hold    = 1'b1;
    end else if (!pair && (is_on || is_off)) begin
      rx_in_ready = 1'b1;
      ctl_on      = is_on & ~is_off;
      ctl_off     = is_off;
    end else begin
      rx_out_valid = rx_in_valid;
    end
  end

  wire rx_fire = rx_in_valid & rx_in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      hold     <= 1'b0;
      hold_off <= 1'b0;
      tx_halt  <= 1'b0;
    end else begin
      mode_q <= mode;
      if (mode_chg) hold <= 1'b0;
      else if (rx_fire && set_hold) begin
        hold     <= 1'b1;
        hold_off <= m_off1;
      end else if (hold_eff && rx_fire) hold <= 1'b0;
      else if (hold_eff && rx_out_valid && rx_out_ready) hold <= 1'b0;
      if (rxm == 2'b00) tx_halt <= 1'b0;
      else if (rx_fire && ctl_off) tx_halt <= 1'b1;
      else if (rx_fire && ctl_on) tx_halt <= 1'b0;
    end
  end

  wire req_any = (send_on | send_off) & (txm != 2'b00);

  always_comb begin
    if (sec_pend) begin
      tx_out_valid = 1'b1;
      tx_out_data  = sec_off ? off_b : on_b;
      tx_in_ready  = 1'b0;
    end else if (req_pend) begin
      tx_out_valid = 1'b1;
      if (txm == 2'b01) tx_out_data = req_off ? off_b : on_b;
      else              tx_out_data = req_off ? off_a : on_a;
      tx_in_ready  = 1'b0;
    end else begin
      tx_out_valid = tx_in_valid & ~tx_halt;
      tx_out_data  = tx_in_data;
      tx_in_ready  = tx_out_ready & ~tx_halt;
    end
  end

  wire tx_acc = tx_out_valid & tx_out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_pend <= 1'b0;
      req_off  <= 1'b0;
      sec_pend <= 1'b0;
      sec_off  <= 1'b0;
    end else begin
      if (sec_pend && tx_acc) sec_pend <= 1'b0;
      else if (!sec_pend && req_pend && tx_acc && txm == 2'b11) begin
        sec_pend <= 1'b1;
        sec_off  <= req_off;
      end
      if (req_any) begin
        req_pend <= 1'b1;
        req_off  <= send_off;
      end else if (!sec_pend && req_pend && tx_acc) req_pend <= 1'b0;
    end
  end

  assert_tx_data_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halt |-> !(tx_in_valid && tx_in_ready));

  assert_pair_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pend |-> (tx_out_valid && !tx_in_ready));

  assert_pair_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pend && !tx_out_ready) |=> sec_pend);

  assert_ctrl_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'b10 && mode[3:2] != 2'b11 && rx_in_valid && rx_in_data == off_a)
      |-> (!rx_out_valid && rx_in_ready));

  assert_halt_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(rx_in_valid && rx_in_ready));

endmodule

// File: tb/tb_uart_xonxoff_ctrl.sv
module tb_uart_xonxoff_ctrl;
  localparam logic [7:0] ON1 = 8'h11, OFF1 = 8'h13, ON2 = 8'h91, OFF2 = 8'h93;

  logic clk = 0, rst_n = 0;
  logic [3:0] mode = 0;
  logic rx_in_valid = 0, rx_out_ready = 1, tx_in_valid = 0, tx_out_ready = 1;
  logic send_on = 0, send_off = 0;
  logic [7:0] rx_in_data = 0, tx_in_data = 0;
  logic rx_in_ready, rx_out_valid, tx_in_ready, tx_out_valid, tx_halt;
  logic [7:0] rx_out_data, tx_out_data;

  int total = 0, bad = 0;
  logic [7:0] got[$], expq[$], txq[$];
  bit mh, mh_off, eh;

  always #5 clk = ~clk;

  uart_xonxoff_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .on_a(ON1), .on_b(ON2), .off_a(OFF1), .off_b(OFF2),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_ready(rx_out_ready),
    .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
    .send_on(send_on), .send_off(send_off), .tx_halt(tx_halt));

  task automatic chk(string r, int act, int e);
    total++;
    if (act != e) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, e);
    end
  endtask

  task automatic cmpq(string r, ref logic [7:0] a[$], ref logic [7:0] e[$]);
    chk({r, " length"}, a.size(), e.size());
    for (int i = 0; i < a.size() && i < e.size(); i++) chk(r, a[i], e[i]);
    a.delete();
    e.delete();
  endtask

  task automatic set_mode(logic [3:0] m);
    @(negedge clk);
    mode = m;
    mh = 0;
    if (m[1:0] == 2'b00) eh = 0;
  endtask

  function automatic void fresh(logic [7:0] b);
    if (b == OFF1) begin mh = 1; mh_off = 1; end
    else if (b == ON1) begin mh = 1; mh_off = 0; end
    else expq.push_back(b);
  endfunction

  function automatic void model(logic [7:0] b);
    bit on, off;
    if (&mode) begin
      if (mh) begin
        if (b == (mh_off ? OFF2 : ON2)) begin mh = 0; eh = mh_off; end
        else begin expq.push_back(mh_off ? OFF1 : ON1); mh = 0; fresh(b); end
      end else fresh(b);
    end else begin
      case (mode[1:0])
        2'b10: begin on = b == ON1; off = b == OFF1; end
        2'b01: begin on = b == ON2; off = b == OFF2; end
        2'b11: begin on = b == ON1 || b == ON2; off = b == OFF1 || b == OFF2; end
        default: begin on = 0; off = 0; end
      endcase
      if (off) eh = 1;
      else if (on) eh = 0;
      else expq.push_back(b);
    end
  endfunction

  task automatic rx_push(logic [7:0] b);
    bit done = 0;
    @(negedge clk);
    rx_in_valid = 1;
    rx_in_data = b;
    while (!done) begin
      #1;
      if (rx_out_valid && rx_out_ready) got.push_back(rx_out_data);
      done = rx_in_ready;
      @(negedge clk);
    end
    rx_in_valid = 0;
    model(b);
  endtask

  task automatic tx_cycles(int n, bit p_on, bit p_off);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      send_on = (i == 0) && p_on;
      send_off = (i == 0) && p_off;
      #1;
      if (tx_out_valid && tx_out_ready) txq.push_back(tx_out_data);
    end
    @(negedge clk);
    send_on = 0;
    send_off = 0;
  endtask

  function automatic logic [7:0] pick();
    case ($urandom % 5)
      0: return ON1;
      1: return OFF1;
      2: return ON2;
      3: return OFF2;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [3:0] mlist [5] = '{4'b0010, 4'b0001, 4'b1011, 4'b1111, 4'b0000};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R1 halt", tx_halt, 0);
    chk("R1 rx_out_valid", rx_out_valid, 0);
    chk("R1 tx_out_valid", tx_out_valid, 0);

    // R2..R5 randomised streams per receive mode
    foreach (mlist[k]) begin
      set_mode(mlist[k]);
      for (int i = 0; i < 150; i++) begin
        rx_push(pick());
        chk($sformatf("R3/R4/R5/R2 halt mode=%b", mode), tx_halt, eh);
      end
      cmpq($sformatf("R2/R3/R4/R5 stream mode=%b", mode), got, expq);
    end

    // R2: control chars pass and halt clears when receive disabled
    set_mode(4'b0010);
    rx_push(OFF1);
    chk("R3 halt set by pause", tx_halt, 1);
    set_mode(4'b0000);
    rx_push(OFF1);
    rx_push(ON1);
    chk("R2 halt cleared", tx_halt, 0);
    cmpq("R2 passthrough", got, expq);

    // R5: pair recognition
    set_mode(4'b1111);
    rx_push(OFF1); rx_push(OFF2);
    chk("R5 pair pause", tx_halt, 1);
    rx_push(ON2);
    chk("R5 lone second not resume", tx_halt, 1);
    rx_push(ON1); rx_push(ON2);
    chk("R5 pair resume", tx_halt, 0);
    // R6: broken pair releases held byte first
    rx_push(ON1); rx_push(8'h41);
    rx_push(OFF1); rx_push(ON1); rx_push(ON2);
    expq.delete();
    expq.push_back(ON2); expq.push_back(ON1); expq.push_back(8'h41); expq.push_back(OFF1);
    cmpq("R6 release order", got, expq);
    chk("R6 halt", tx_halt, 0);

    // R7: mode change drops partial match
    rx_push(OFF1);
    set_mode(4'b1011);
    set_mode(4'b1111);
    rx_push(OFF2);
    expq.delete();
    expq.push_back(OFF2);
    cmpq("R7 partial dropped", got, expq);
    chk("R7 no pause", tx_halt, 0);

    // transmit side with continuous data 0x55
    tx_in_valid = 1;
    tx_in_data = 8'h55;
    set_mode(4'b1100);
    tx_cycles(6, 0, 1);
    txq.delete();
    expq.delete();
    // first cycle 55 then off_a, off_b, 55...
    tx_cycles(6, 0, 1);
    expq = '{8'h55, OFF1, OFF2, 8'h55, 8'h55, 8'h55};
    cmpq("R10 R11 pause pair", txq, expq);
    tx_cycles(5, 1, 0);
    expq = '{8'h55, ON1, ON2, 8'h55, 8'h55};
    cmpq("R10 resume pair", txq, expq);
    set_mode(4'b1000);
    tx_cycles(4, 1, 0);
    expq = '{8'h55, ON1, 8'h55, 8'h55};
    cmpq("R9 first char", txq, expq);
    set_mode(4'b0100);
    tx_cycles(4, 0, 1);
    expq = '{8'h55, OFF2, 8'h55, 8'h55};
    cmpq("R9 second char", txq, expq);
    set_mode(4'b0000);
    tx_cycles(4, 1, 1);
    expq = '{8'h55, 8'h55, 8'h55, 8'h55};
    cmpq("R12 requests ignored", txq, expq);

    // R8: halt blocks data, control still sent
    set_mode(4'b1010);
    tx_in_valid = 0;
    rx_push(OFF1);
    chk("R8 halt", tx_halt, 1);
    tx_in_valid = 1;
    txq.delete();
    tx_cycles(5, 1, 0);
    #1;
    chk("R8 tx_in_ready low", tx_in_ready, 0);
    expq = '{ON1};
    cmpq("R8 only control", txq, expq);
    rx_push(ON1);
    chk("R8 halt released", tx_halt, 0);
    txq.delete();
    tx_cycles(2, 0, 0);
    expq = '{8'h55, 8'h55};
    cmpq("R8 data resumes", txq, expq);
    tx_in_valid = 0;
    got.delete();

    finish_up();
  end
endmodule